// File: doc/BRIEF.md
# Dual-Mode Set-Associative Cache Controller

This block is a small 4-way, 16-set cache placed between a 32-bit CPU and external memory. Every line holds four 32-bit words (16 bytes) and carries a valid bit, a tag, a dirty bit and a 2-bit age that orders the ways of its set from most to least recently used. A mode input picks one of two write policies at run time. In write-through mode, writes always go out to memory and a write miss allocates nothing. In write-back mode, writes stay in the cache, and a write miss first refills the line and then merges the CPU word into it.

The CPU holds a request (fetch, operand read or operand write) until the block raises ready. Hits are answered combinationally in the cycle of the request. The memory side has one request/acknowledge channel that carries three kinds of transfer: 16-byte refill reads, single-word writes and 16-byte line write-backs.

A dirty victim is copied into a one-entry write-back buffer, so its refill can be issued first. The buffer is written out once the CPU has been answered. Hits are still served while the buffer drains. Any access that needs the memory channel waits until the buffer is empty.

Top module: `dual_mode_cache`

## Requirements
- R1: After reset, cpuReady and memReq are low and every line is invalid, so the first access to any address misses.
- R2: A fetch (cpuKind 0) or read (cpuKind 1) that hits raises cpuReady in the same cycle as the request, with the cached word on cpuRdata, and makes no memory transfer.
- R3: A fetch or read miss issues exactly one refill (memKind 0) at the line-aligned address. cpuReady rises in the cycle memAck is high, and cpuRdata carries word addr[3:2] of memRdata, where word i sits at bits 32i+31:32i.
- R4: A miss whose victim is dirty, in either mode, issues its refill first. It then issues one line write (memKind 2) of the victim's old data at the victim's line address, in word order as in R3.
- R5: A miss whose victim is clean issues only the refill.
- R6: In write-back mode (wbMode 1), a write (cpuKind 2) that hits is acknowledged in the request cycle, makes no memory transfer, updates the cached word and marks the line dirty.
- R7: In write-through mode (wbMode 0), a write that hits issues one word write (memKind 1, data on memWdata[31:0], byte address on memAddr). It is acknowledged in the memAck cycle and also updates the cached word.
- R8: In write-through mode, a write miss issues only a word write and allocates no line, so a later read of that address misses.
- R9: In write-back mode, a write miss refills the line, merges the CPU word into it and marks the line dirty.
- R10: The victim is the lowest-numbered invalid way if one exists, otherwise the least recently used way. Every access updates the age order except a write-through write miss, which leaves it unchanged.
- R11: Hits are served while the write-back buffer drains. A miss or write-through write waits until the buffer is empty.
- R12: Once memReq is raised, memReq, memKind and memAddr stay stable until the cycle memAck is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wbMode | input | 1 | 1 = write-back with allocate, 0 = write-through without allocate |
| cpuReq | input | 1 | CPU request, held until cpuReady |
| cpuKind | input | 2 | 0 fetch, 1 read, 2 write |
| cpuAddr | input | 32 | CPU byte address |
| cpuWdata | input | 32 | CPU write word |
| cpuRdata | output | 32 | Read word, valid while cpuReady is high |
| cpuReady | output | 1 | Access completes at the next clock edge |
| memReq | output | 1 | Memory request, held until memAck |
| memKind | output | 2 | 0 line refill, 1 word write, 2 line write-back |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 128 | Write data: a whole line, or one word in bits 31:0 |
| memRdata | input | 128 | Refill data, valid while memAck is high |
| memAck | input | 1 | One-cycle acknowledge of the held request |

## Verification
Hit results (ready, read data, write-hit updates) are due in the same cycle as the request. Miss and write-through results are due in the cycle memAck is high. The write-back of a dirty victim starts in the cycle after the refill acknowledge. The bench drives inputs on the falling edge and samples one time step later, counting the falling edges it waited: a hit must show zero wait. Memory transfer counts and written-back memory contents are compared only after a settling gap long enough for any pending buffer drain to finish.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    CPU_FETCH = 2'd0,
    CPU_READ  = 2'd1,
    CPU_WRITE = 2'd2
  } cpuKind_e;

  typedef enum logic [1:0] {
    MEM_REFILL = 2'd0,
    MEM_WORD   = 2'd1,
    MEM_LINE   = 2'd2
  } memKind_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic touchHit;   // age update on the hit way
    logic writeHit;   // store cpu word into the hit way
    logic latchMiss;  // capture victim way at miss start
    logic loadBuf;    // copy dirty victim into write-back buffer
    logic fill;       // install refill line into the victim way
    logic fillMerge;  // merge cpu word into the refill line
    logic fillDirty;  // installed line starts dirty
    logic bufDone;    // write-back buffer acknowledged
  } strobe_t;
endpackage

// File: rtl/cache_dp.sv
module cache_dp
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wbMode,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [WORD_W-1:0]            cpuWdata,
  input  strobe_t                      strobe,
  input  memKind_e                     memKind,
  input  logic [LINE_WORDS*WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0]            cpuRdata,
  output logic                         hit,
  output logic                         victimDirty,
  output logic                         bufValid,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [LINE_WORDS*WORD_W-1:0] memWdata
);
  localparam int BYTE_OFF = $clog2(LINE_WORDS) + 2;
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - BYTE_OFF - IDX_W;
  localparam int WAY_W    = $clog2(WAYS);
  localparam int WSEL_W   = $clog2(LINE_WORDS);
  localparam int LINE_W   = LINE_WORDS * WORD_W;

  logic [TAG_W-1:0]  tagMem   [SETS][WAYS];
  logic              validMem [SETS][WAYS];
  logic              dirtyMem [SETS][WAYS];
  logic [LINE_W-1:0] dataMem  [SETS][WAYS];
  logic [WAY_W-1:0]  age      [SETS][WAYS];

  logic [IDX_W-1:0]  setIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [WSEL_W-1:0] wsel;
  logic [WAYS-1:0]   wayHit;
  logic [WAY_W-1:0]  hitWay, vicWay, missWay, touchWay;
  logic              gotInv, touchEn;
  logic [LINE_W-1:0] fillLine, hitLine;
  logic [ADDR_W-1:0] bufAddr;
  logic [LINE_W-1:0] bufData;

  assign setIdx = cpuAddr[BYTE_OFF +: IDX_W];
  assign reqTag = cpuAddr[ADDR_W-1 -: TAG_W];
  assign wsel   = cpuAddr[2 +: WSEL_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayHit[w] = validMem[setIdx][w] && (tagMem[setIdx][w] == reqTag);
  end

  assign hit = |wayHit;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (wayHit[w]) hitWay = WAY_W'(w);
  end

  // victim: lowest invalid way, else the oldest way
  always_comb begin
    vicWay = '0;
    gotInv = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!validMem[setIdx][w] && !gotInv) begin
        vicWay = WAY_W'(w);
        gotInv = 1'b1;
      end
    end
    if (!gotInv) begin
      for (int w = 0; w < WAYS; w++)
        if (age[setIdx][w] == WAY_W'(WAYS - 1)) vicWay = WAY_W'(w);
    end
  end

  assign victimDirty = validMem[setIdx][vicWay] && dirtyMem[setIdx][vicWay];
  assign hitLine     = dataMem[setIdx][hitWay];

  always_comb begin
    fillLine = memRdata;
    if (strobe.fillMerge) fillLine[int'(wsel)*WORD_W +: WORD_W] = cpuWdata;
  end

  assign cpuRdata = strobe.fill ? memRdata[int'(wsel)*WORD_W +: WORD_W]
                                : hitLine[int'(wsel)*WORD_W +: WORD_W];

  assign touchEn  = strobe.touchHit || strobe.fill;
  assign touchWay = strobe.fill ? missWay : hitWay;

  // state bits and age order, reset to empty with ages 0..WAYS-1
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          validMem[s][w] <= 1'b0;
          dirtyMem[s][w] <= 1'b0;
          age[s][w]      <= WAY_W'(w);
        end
      end
      missWay  <= '0;
      bufValid <= 1'b0;
    end else begin
      if (strobe.latchMiss) missWay <= vicWay;
      if (strobe.writeHit && wbMode) dirtyMem[setIdx][hitWay] <= 1'b1;
      if (strobe.fill) begin
        validMem[setIdx][missWay] <= 1'b1;
        dirtyMem[setIdx][missWay] <= strobe.fillDirty;
      end
      if (touchEn) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touchWay)
            age[setIdx][w] <= '0;
          else if (age[setIdx][w] < age[setIdx][touchWay])
            age[setIdx][w] <= age[setIdx][w] + 1'b1;
        end
      end
      if (strobe.loadBuf) bufValid <= 1'b1;
      else if (strobe.bufDone) bufValid <= 1'b0;
    end
  end

  // tag and data storage, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.writeHit)
      dataMem[setIdx][hitWay][int'(wsel)*WORD_W +: WORD_W] <= cpuWdata;
    if (strobe.fill) begin
      dataMem[setIdx][missWay] <= fillLine;
      tagMem[setIdx][missWay]  <= reqTag;
    end
    if (strobe.loadBuf) begin
      bufAddr <= {tagMem[setIdx][vicWay], setIdx, {BYTE_OFF{1'b0}}};
      bufData <= dataMem[setIdx][vicWay];
    end
  end

  always_comb begin
    case (memKind)
      MEM_REFILL: memAddr = {cpuAddr[ADDR_W-1:BYTE_OFF], {BYTE_OFF{1'b0}}};
      MEM_WORD:   memAddr = cpuAddr;
      default:    memAddr = bufAddr;
    endcase
    memWdata = (memKind == MEM_LINE) ? bufData : LINE_W'(cpuWdata);
  end

  // R11: the buffer is only loaded while empty
  a_r11_buf_free: assert property (@(posedge clk) disable iff (rst)
    strobe.loadBuf |-> !bufValid);

  // R10: ages of every set remain a permutation
  logic [SETS-1:0] permOk;
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      logic [WAYS-1:0] seen;
      seen = '0;
      for (int w = 0; w < WAYS; w++) seen[age[s][w]] = 1'b1;
      permOk[s] = &seen;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_perm
    a_r10_age_perm: assert property (@(posedge clk) disable iff (rst)
      permOk[s]);
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wbMode,
  input  logic       cpuReq,
  input  logic [1:0] cpuKind,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       bufValid,
  input  logic       memAck,
  output logic       cpuReady,
  output logic       memReq,
  output memKind_e   memKind,
  output strobe_t    strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_REFILL, ST_WORD} state_e;

  state_e state, nextState;
  logic   isWrite;

  assign isWrite = (cpuKind == CPU_WRITE);

  always_comb begin
    nextState = state;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memKind   = MEM_REFILL;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (bufValid) begin
          memReq         = 1'b1;
          memKind        = MEM_LINE;
          strobe.bufDone = memAck;
        end
        if (cpuReq) begin
          if (isWrite && !wbMode) begin
            if (!bufValid) nextState = ST_WORD;
          end else if (hit) begin
            cpuReady        = 1'b1;
            strobe.touchHit = 1'b1;
            strobe.writeHit = isWrite;
          end else if (!bufValid) begin
            strobe.latchMiss = 1'b1;
            strobe.loadBuf   = victimDirty;
            nextState        = ST_REFILL;
          end
        end
      end
      ST_WORD: begin
        memReq  = 1'b1;
        memKind = MEM_WORD;
        if (memAck) begin
          cpuReady        = 1'b1;
          strobe.writeHit = hit;
          strobe.touchHit = hit;
          nextState       = ST_IDLE;
        end
      end
      ST_REFILL: begin
        memReq  = 1'b1;
        memKind = MEM_REFILL;
        if (memAck) begin
          cpuReady         = 1'b1;
          strobe.fill      = 1'b1;
          strobe.fillMerge = isWrite;
          strobe.fillDirty = isWrite;
          nextState        = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  // R7: a write-through write is answered only together with memory
  a_r7_wt_ack: assert property (@(posedge clk) disable iff (rst)
    (cpuReady && isWrite && !wbMode) |-> memAck);

  // R2: an answer without a memory state is always a hit
  a_r2_hit_quiet: assert property (@(posedge clk) disable iff (rst)
    (cpuReady && state == ST_IDLE) |-> hit);
endmodule

// File: rtl/dual_mode_cache.sv
module dual_mode_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wbMode,
  input  logic                         cpuReq,
  input  logic [1:0]                   cpuKind,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [WORD_W-1:0]            cpuWdata,
  output logic [WORD_W-1:0]            cpuRdata,
  output logic                         cpuReady,
  output logic                         memReq,
  output logic [1:0]                   memKind,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [LINE_WORDS*WORD_W-1:0] memWdata,
  input  logic [LINE_WORDS*WORD_W-1:0] memRdata,
  input  logic                         memAck
);
  strobe_t  strobe;
  memKind_e kindSel;
  logic     hit, victimDirty, bufValid;

  cache_ctrl i_ctrl (
    .clk(clk), .rst(rst), .wbMode(wbMode), .cpuReq(cpuReq), .cpuKind(cpuKind),
    .hit(hit), .victimDirty(victimDirty), .bufValid(bufValid), .memAck(memAck),
    .cpuReady(cpuReady), .memReq(memReq), .memKind(kindSel), .strobe(strobe)
  );

  cache_dp #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS)
  ) i_dp (
    .clk(clk), .rst(rst), .wbMode(wbMode), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .strobe(strobe), .memKind(kindSel),
    .memRdata(memRdata), .cpuRdata(cpuRdata), .hit(hit),
    .victimDirty(victimDirty), .bufValid(bufValid), .memAddr(memAddr),
    .memWdata(memWdata)
  );

  assign memKind = kindSel;

  // R12: a raised memory request holds its kind and address until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memKind) && $stable(memAddr)));
endmodule

// File: tb/test_dual_mode_cache.sv
`timescale 1ns/100ps
module test_dual_mode_cache;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wbMode = 1'b1;
  logic         cpuReq = 1'b0;
  logic [1:0]   cpuKind = 2'd0;
  logic [31:0]  cpuAddr = '0;
  logic [31:0]  cpuWdata = '0;
  logic [31:0]  cpuRdata;
  logic         cpuReady;
  logic         memReq;
  logic [1:0]   memKind;
  logic [31:0]  memAddr;
  logic [127:0] memWdata;
  logic [127:0] memRdata;
  logic         memAck;

  always #2.5 clk = ~clk;

  dual_mode_cache i_dual_mode_cache (
    .clk(clk), .rst(rst), .wbMode(wbMode), .cpuReq(cpuReq), .cpuKind(cpuKind),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuReady(cpuReady), .memReq(memReq), .memKind(memKind),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck)
  );

  // ---------------- memory model ----------------
  localparam int LAT = 3;
  logic [31:0] mem [1024];
  int          lat, refCnt, wtCnt, wbCnt, holdErr;
  logic        pendReq;
  logic [31:0] pendAddr;
  logic [1:0]  pendKind;
  logic [9:0]  lineBase;

  function automatic logic [31:0] initWord(input int i);
    return 32'hC0DE_0000 + i;
  endfunction

  assign lineBase = {memAddr[11:4], 2'b00};
  assign memRdata = {mem[lineBase + 10'd3], mem[lineBase + 10'd2],
                     mem[lineBase + 10'd1], mem[lineBase]};

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= initWord(i);
      memAck <= 1'b0; lat <= 0; refCnt <= 0; wtCnt <= 0; wbCnt <= 0;
      holdErr <= 0; pendReq <= 1'b0;
    end else begin
      if (pendReq && !memReq && !memAck) holdErr <= holdErr + 1;
      if (memAck) begin
        memAck <= 1'b0; lat <= 0; pendReq <= 1'b0;
        case (memKind)
          2'd0: refCnt <= refCnt + 1;
          2'd1: begin
            wtCnt <= wtCnt + 1;
            mem[memAddr[11:2]] <= memWdata[31:0];
          end
          default: begin
            wbCnt <= wbCnt + 1;
            for (int k = 0; k < 4; k++) mem[lineBase + 10'(k)] <= memWdata[32*k +: 32];
          end
        endcase
      end else if (memReq) begin
        if (pendReq && (memAddr != pendAddr || memKind != pendKind)) holdErr <= holdErr + 1;
        pendReq <= 1'b1; pendAddr <= memAddr; pendKind <= memKind;
        if (lat == LAT) memAck <= 1'b1;
        else lat <= lat + 1;
      end else begin
        pendReq <= 1'b0;
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] refMem [1024];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doAccess(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int waited, output bit sawDrain);
    @(negedge clk);
    cpuReq = 1'b1; cpuKind = k; cpuAddr = a; cpuWdata = d;
    waited = 0;
    #1;
    while (!cpuReady && waited < 1000) begin
      @(negedge clk); #1;
      waited++;
    end
    rd = cpuRdata;
    sawDrain = memReq && (memKind == 2'd2);
    if (k == 2'd2) refMem[a[11:2]] = d;
    @(negedge clk);
    cpuReq = 1'b0;
  endtask

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  // kind(2) wb(1) addr(12) wdata(32) expRefill expWordWr expLineWr
  localparam int NV = 15;
  localparam logic [49:0] VEC [NV] = '{
    {2'd1, 1'b1, 12'h100, 32'h0,         3'b100},  // R3 R1 first read misses
    {2'd1, 1'b1, 12'h104, 32'h0,         3'b000},  // R2 read hit
    {2'd2, 1'b1, 12'h108, 32'hDEAD0001,  3'b000},  // R6 write-back write hit
    {2'd1, 1'b1, 12'h108, 32'h0,         3'b000},  // R6 hit returns new word
    {2'd2, 1'b1, 12'h200, 32'hBEEF0002,  3'b100},  // R9 write miss allocates
    {2'd0, 1'b1, 12'h300, 32'h0,         3'b100},  // R3 fetch miss
    {2'd1, 1'b1, 12'h400, 32'h0,         3'b100},  // R5 clean victim
    {2'd1, 1'b1, 12'h500, 32'h0,         3'b101},  // R4 R10 dirty LRU victim
    {2'd1, 1'b1, 12'h108, 32'h0,         3'b101},  // R4 written-back data
    {2'd2, 1'b0, 12'h504, 32'hCAFE0003,  3'b010},  // R7 write-through hit
    {2'd1, 1'b0, 12'h504, 32'h0,         3'b000},  // R7 cache updated
    {2'd2, 1'b0, 12'h600, 32'hF00D0004,  3'b010},  // R8 write-through miss
    {2'd1, 1'b0, 12'h600, 32'h0,         3'b100},  // R8 no allocation
    {2'd1, 1'b0, 12'h400, 32'h0,         3'b000},  // R10 age order kept
    {2'd1, 1'b0, 12'h300, 32'h0,         3'b100}   // R10 LRU victim
  };

  initial begin
    logic [31:0] rd;
    int waited;
    bit sawDrain;
    for (int i = 0; i < 1024; i++) refMem[i] = initWord(i);
    repeat (4) @(negedge clk);
    check(cpuReady == 1'b0, "R1", "cpuReady in reset", 32'(cpuReady), 32'd0);
    check(memReq == 1'b0, "R1", "memReq in reset", 32'(memReq), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(cpuReady == 1'b0 && memReq == 1'b0, "R1", "idle after reset",
          32'({cpuReady, memReq}), 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0]  k;
      logic [31:0] a, d;
      int r0, w0, b0;
      k = VEC[v][49:48];
      wbMode = VEC[v][47];
      a = {20'h0, VEC[v][46:35]};
      d = VEC[v][34:3];
      r0 = refCnt; w0 = wtCnt; b0 = wbCnt;
      doAccess(k, a, d, rd, waited, sawDrain);
      settle();
      check(refCnt - r0 == int'(VEC[v][2]), "R3 R5", $sformatf("vec %0d refills", v),
            32'(refCnt - r0), 32'(VEC[v][2]));
      check(wtCnt - w0 == int'(VEC[v][1]), "R7 R8", $sformatf("vec %0d word writes", v),
            32'(wtCnt - w0), 32'(VEC[v][1]));
      check(wbCnt - b0 == int'(VEC[v][0]), "R4", $sformatf("vec %0d line writes", v),
            32'(wbCnt - b0), 32'(VEC[v][0]));
      if (k != 2'd2)
        check(rd == refMem[a[11:2]], "R2 R3", $sformatf("vec %0d read data", v),
              rd, refMem[a[11:2]]);
      if (VEC[v][2:0] == 3'b000)
        check(waited == 0, "R2 R6", $sformatf("vec %0d hit latency", v),
              32'(waited), 32'd0);
    end
    check(mem[12'h200 >> 2] == 32'hBEEF0002, "R9", "merged word written back",
          mem[12'h200 >> 2], 32'hBEEF0002);
    check(mem[12'h504 >> 2] == 32'hCAFE0003, "R7", "write-through word in memory",
          mem[12'h504 >> 2], 32'hCAFE0003);

    // R11: buffer occupancy in set 1, write-back mode
    wbMode = 1'b1;
    for (int t = 1; t <= 4; t++) begin
      doAccess(2'd2, 32'h010 + 32'(t << 8), 32'h1111_0000 + 32'(t), rd, waited, sawDrain);
      settle();
    end
    begin
      int b0;
      b0 = wbCnt;
      doAccess(2'd2, 32'h510, 32'h5555_0005, rd, waited, sawDrain);
      doAccess(2'd2, 32'h610, 32'h6666_0006, rd, waited, sawDrain);
      check(waited > LAT, "R11", "miss waits for buffer", 32'(waited), 32'(LAT + 1));
      doAccess(2'd1, 32'h410, 32'h0, rd, waited, sawDrain);
      check(waited == 0, "R11", "hit during drain latency", 32'(waited), 32'd0);
      check(sawDrain, "R11", "drain pending during hit", 32'(sawDrain), 32'd1);
      check(rd == 32'h1111_0004, "R11", "hit data during drain", rd, 32'h1111_0004);
      settle();
      check(wbCnt - b0 == 2, "R4 R11", "two line writes", 32'(wbCnt - b0), 32'd2);
      check(mem[12'h110 >> 2] == 32'h1111_0001, "R4", "first victim data",
            mem[12'h110 >> 2], 32'h1111_0001);
      check(mem[12'h210 >> 2] == 32'h1111_0002, "R4", "second victim data",
            mem[12'h210 >> 2], 32'h1111_0002);
      doAccess(2'd1, 32'h610, 32'h0, rd, waited, sawDrain);
      check(waited == 0 && rd == 32'h6666_0006, "R9", "allocated line hit", rd, 32'h6666_0006);
    end
    check(holdErr == 0, "R12", "request stability", 32'(holdErr), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule